// File: doc/BRIEF.md
# Bang-Bang BPSK Symbol Slicer and Phase Stepper

This block is the digital core of a binary phase shift keying receiver that works only from 1-bit samples. An external half-rate sampler captures the received carrier on both edges of a recovered clock and at the zero crossings between those points. The block runs in a slow clock domain at one quarter of the carrier rate, so it takes in four carrier periods on every slow cycle. From those samples it recovers one symbol bit per carrier period. It also drives one 6-bit phase code, and both external phase interpolators take that same code.

Timing error comes from early/late votes on the rising-edge samples and the zero-crossing sample between them. The signed net vote moves the code by one step, down or up, or holds it. When locked, a correct sample pair reads 10 or 01. Inverting the falling-edge sample turns these into 11 or 00, so the rising-edge sample is the symbol bit. A lock detector watches for bang-bang dither in the code, and symbol output is released only after it sees that dither. Because the BPSK carrier flips by 180 degrees, the loop settles at either of two points half a carrier period apart.

Top module: `bpsk_bb_demod`

## Requirements
- R1: While rst_ni is low, code_o, lock_o, valid_o and bits_o are all zero.
- R2: Lane k (bit k of each input bus, bit 0 earliest in time) forms the triple (a, zc_i[k], rise_i[k]). Here a is rise_i[k-1], or for lane 0 the last rising sample of the previous slow cycle. If a differs from rise_i[k], the lane votes late when zc_i[k] equals rise_i[k] and early when zc_i[k] equals a. Equal samples give no vote.
- R3: At each slow clock edge, code_o goes up by one if the late votes exceed the early votes, goes down by one if the early votes are more, and otherwise holds.
- R4: The code wraps modulo 64: 63 stepped up gives 0, and 0 stepped down gives 63.
- R5: rise_i[3] is carried into the next slow cycle as lane 0's earlier sample. In the first slow cycle after reset, lane 0 casts no vote.
- R6: A cycle that holds the code, or that steps it in a direction other than the previous cycle's step, counts as dither. lock_o rises at the edge that completes 16 consecutive dither cycles after reset.
- R7: A cycle that steps the code in the same direction as the previous cycle clears the dither count, and lock_o falls at that edge.
- R8: If rise_i[k] differs from fall_i[k], the decided bit for lane k is rise_i[k].
- R9: If rise_i[k] equals fall_i[k], lane k repeats the previous decided bit in time order. Lane 0 uses the last bit of the previous slow cycle, which is 0 after reset.
- R10: bits_o carries the four decided bits one slow cycle after their samples. valid_o equals lock_o as it stood during the sampling cycle. bits_o is zero whenever valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow loop clock, a quarter of the carrier rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rise_i | input | 4 | Rising-edge samples, one per carrier period, bit 0 earliest |
| fall_i | input | 4 | Falling-edge samples, one per carrier period |
| zc_i | input | 4 | Zero-crossing samples, each ahead of the same-index rising sample |
| code_o | output | 6 | Phase code for both interpolators |
| lock_o | output | 1 | Loop is dithering around a lock point |
| bits_o | output | 4 | Recovered symbols, bit 0 earliest |
| valid_o | output | 1 | bits_o holds valid symbols |

## Verification
Inputs presented in one slow cycle show up on code_o, lock_o, bits_o and valid_o right after the next rising edge. The one exception is valid_o, which reports the lock state that held during the sampling cycle and so lags lock_o by one edge. The bench changes inputs 2 ns after an edge and reads every result 2 ns after the following edge. That makes each check land exactly one register stage after its stimulus. The lock tests count edges from reset, so the rise of lock_o is checked on the 15th and 16th edges, and its fall on the edge of the second same-direction step.

// File: rtl/bpsk_bb_pkg.sv
package bpsk_bb_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2
  } step_e;
endpackage

// File: rtl/bb_vote.sv
module bb_vote #(
  parameter int LANES = 4,
  parameter int NET_W = 4
) (
  input  logic [LANES-1:0]        rise_i,
  input  logic [LANES-1:0]        zc_i,
  input  logic                    prev_i,
  input  logic                    prev_vld_i,
  output logic signed [NET_W-1:0] net_o
);
  logic [LANES-1:0] lead_s;
  logic [LANES-1:0] lane_en;
  logic [LANES-1:0] late_v;
  logic [LANES-1:0] early_v;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_first
      assign lead_s[g]  = prev_i;
      assign lane_en[g] = prev_vld_i;
    end else begin : g_rest
      assign lead_s[g]  = rise_i[g-1];
      assign lane_en[g] = 1'b1;
    end
    assign late_v[g]  = lane_en[g] && (lead_s[g] != rise_i[g]) && (zc_i[g] == rise_i[g]);
    assign early_v[g] = lane_en[g] && (lead_s[g] != rise_i[g]) && (zc_i[g] == lead_s[g]);
  end

  always_comb begin
    net_o = '0;
    for (int i = 0; i < LANES; i++) begin
      net_o = net_o + NET_W'(late_v[i]) - NET_W'(early_v[i]);
    end
  end
endmodule

// File: rtl/bb_loop_ctrl.sv
module bb_loop_ctrl
  import bpsk_bb_pkg::*;
#(
  parameter int CODE_W   = 6,
  parameter int NET_W    = 4,
  parameter int LOCK_CYC = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [NET_W-1:0] net_i,
  output logic [CODE_W-1:0]       code_o,
  output logic                    lock_o
);
  localparam int CNT_W = $clog2(LOCK_CYC + 1);

  step_e             step_s;
  step_e             prev_step_q;
  logic [CODE_W-1:0] code_q;
  logic [CNT_W-1:0]  dith_cnt_q;
  logic              monotone_s;

  always_comb begin
    if (net_i > 0)      step_s = STEP_UP;
    else if (net_i < 0) step_s = STEP_DN;
    else                step_s = STEP_HOLD;
  end

  assign monotone_s = (step_s != STEP_HOLD) && (step_s == prev_step_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q      <= '0;
      prev_step_q <= STEP_HOLD;
      dith_cnt_q  <= '0;
    end else begin
      prev_step_q <= step_s;
      case (step_s)
        STEP_UP: code_q <= code_q + 1'b1;
        STEP_DN: code_q <= code_q - 1'b1;
        default: code_q <= code_q;
      endcase
      if (monotone_s)                          dith_cnt_q <= '0;
      else if (dith_cnt_q != CNT_W'(LOCK_CYC)) dith_cnt_q <= dith_cnt_q + 1'b1;
    end
  end

  assign code_o = code_q;
  assign lock_o = (dith_cnt_q == CNT_W'(LOCK_CYC));

  // R3
  code_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (code_q == $past(code_q)) || (code_q == CODE_W'($past(code_q) + 1'b1))
          || (code_q == CODE_W'($past(code_q) - 1'b1)));

  // R3
  code_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (net_i == 0) |=> $stable(code_q));

  // R7
  lock_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && monotone_s) |=> !lock_o);
endmodule

// File: rtl/bb_slicer.sv
module bb_slicer #(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0] rise_i,
  input  logic [LANES-1:0] fall_i,
  input  logic             last_i,
  output logic [LANES-1:0] bits_o
);
  logic [LANES:0] chain_s;

  assign chain_s[0] = last_i;

  for (genvar g = 0; g < LANES; g++) begin : g_bit
    // inverted falling sample agrees with rising sample: clean decision
    assign bits_o[g]    = (rise_i[g] == ~fall_i[g]) ? rise_i[g] : chain_s[g];
    assign chain_s[g+1] = bits_o[g];
  end
endmodule

// File: rtl/bpsk_bb_demod.sv
module bpsk_bb_demod #(
  parameter int LANES    = 4,
  parameter int CODE_W   = 6,
  parameter int LOCK_CYC = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LANES-1:0]  rise_i,
  input  logic [LANES-1:0]  fall_i,
  input  logic [LANES-1:0]  zc_i,
  output logic [CODE_W-1:0] code_o,
  output logic              lock_o,
  output logic [LANES-1:0]  bits_o,
  output logic              valid_o
);
  localparam int NET_W = $clog2(LANES + 1) + 1;

  logic                    carry_q;
  logic                    carry_vld_q;
  logic                    last_bit_q;
  logic [LANES-1:0]        bits_q;
  logic                    valid_q;
  logic signed [NET_W-1:0] net_s;
  logic [LANES-1:0]        dec_s;

  bb_vote #(.LANES(LANES), .NET_W(NET_W)) i_vote (
    .rise_i     (rise_i),
    .zc_i       (zc_i),
    .prev_i     (carry_q),
    .prev_vld_i (carry_vld_q),
    .net_o      (net_s)
  );

  bb_loop_ctrl #(.CODE_W(CODE_W), .NET_W(NET_W), .LOCK_CYC(LOCK_CYC)) i_loop (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .net_i  (net_s),
    .code_o (code_o),
    .lock_o (lock_o)
  );

  bb_slicer #(.LANES(LANES)) i_slicer (
    .rise_i (rise_i),
    .fall_i (fall_i),
    .last_i (last_bit_q),
    .bits_o (dec_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      carry_q     <= 1'b0;
      carry_vld_q <= 1'b0;
      last_bit_q  <= 1'b0;
      bits_q      <= '0;
      valid_q     <= 1'b0;
    end else begin
      carry_q     <= rise_i[LANES-1];
      carry_vld_q <= 1'b1;
      last_bit_q  <= dec_s[LANES-1];
      valid_q     <= lock_o;
      bits_q      <= lock_o ? dec_s : '0;
    end
  end

  assign bits_o  = bits_q;
  assign valid_o = valid_q;

  // R10
  quiet_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (bits_o == '0));

  // R10
  valid_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (valid_o == $past(lock_o)));

  // R5
  carry_seen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> carry_vld_q);
endmodule

// File: tb/test_bpsk_bb_demod.sv
module test_bpsk_bb_demod;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] rise_i = '0;
  logic [3:0] fall_i = '0;
  logic [3:0] zc_i = '0;
  logic [5:0] code_o;
  logic       lock_o;
  logic [3:0] bits_o;
  logic       valid_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk_i = ~clk_i;

  bpsk_bb_demod i_bpsk_bb_demod (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rise_i  (rise_i),
    .fall_i  (fall_i),
    .zc_i    (zc_i),
    .code_o  (code_o),
    .lock_o  (lock_o),
    .bits_o  (bits_o),
    .valid_o (valid_o)
  );

  // {rise, zc, expected code after the edge}; fall = ~rise
  localparam logic [13:0] VEC [9] = '{
    {4'b1111, 4'b0000, 6'd0},   // R5 lane 0 silent after reset
    {4'b0000, 4'b0000, 6'd1},   // R5 carried 1 -> late
    {4'b1111, 4'b1111, 6'd2},   // R2 late
    {4'b0101, 4'b1010, 6'd1},   // R2 three early
    {4'b0101, 4'b1111, 6'd1},   // R3 two late two early
    {4'b0000, 4'b0000, 6'd1},   // R2 no transitions
    {4'b1000, 4'b0000, 6'd0},   // R2 early on lane 3
    {4'b0000, 4'b0001, 6'd63},  // R4 wrap down
    {4'b1111, 4'b1111, 6'd0}    // R4 wrap up
  };

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] r, input logic [3:0] f, input logic [3:0] z);
    rise_i = r;
    fall_i = f;
    zc_i   = z;
    @(posedge clk_i);
    #2;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    rise_i = '0; fall_i = '0; zc_i = '0;
    #10;
    chk("R1 code", code_o, 0);
    chk("R1 lock", lock_o, 0);
    chk("R1 valid", valid_o, 0);
    chk("R1 bits", bits_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();

    // vector walk: R2 R3 R4 R5, output quiet while unlocked (R10)
    for (int i = 0; i < 9; i++) begin
      apply(VEC[i][13:10], ~VEC[i][13:10], VEC[i][9:6]);
      chk("R3 code", code_o, int'(VEC[i][5:0]));
      chk("R10 valid", valid_o, 0);
      chk("R10 bits", bits_o, 0);
    end

    // R6 lock after 16 dither cycles
    do_reset();
    for (int i = 0; i < 15; i++) apply(4'b0000, 4'b1111, 4'b0000);
    chk("R6 lock at 15", lock_o, 0);
    apply(4'b0000, 4'b1111, 4'b0000);
    chk("R6 lock at 16", lock_o, 1);
    chk("R10 valid lags", valid_o, 0);

    // R8 clean pairs
    apply(4'b0110, 4'b1001, 4'b1010);
    chk("R8 bits", bits_o, 4'b0110);
    chk("R10 valid", valid_o, 1);
    chk("R6 lock held", lock_o, 1);

    // R9 ambiguous lanes repeat previous bit
    apply(4'b0011, 4'b0110, 4'b0101);
    chk("R9 bits", bits_o, 4'b0011);
    chk("R3 hold", code_o, 0);

    apply(4'b1000, 4'b0111, 4'b0000);
    chk("R8 bits", bits_o, 4'b1000);
    chk("R4 code", code_o, 63);

    apply(4'b1111, 4'b1111, 4'b0000);
    chk("R9 carried bit", bits_o, 4'b1111);
    chk("R6 lock after alternation", lock_o, 1);

    // R7 two downs in a row
    apply(4'b0000, 4'b1111, 4'b0001);
    chk("R3 code", code_o, 62);
    chk("R6 lock", lock_o, 1);
    apply(4'b1111, 4'b0000, 4'b0000);
    chk("R3 code", code_o, 61);
    chk("R7 lock", lock_o, 0);
    chk("R10 valid", valid_o, 1);
    chk("R10 bits", bits_o, 4'b1111);
    apply(4'b1111, 4'b0000, 4'b1111);
    chk("R10 valid off", valid_o, 0);
    chk("R10 bits off", bits_o, 0);

    do_reset();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule